// File: doc/BRIEF.md
# Multi-Core Mailbox Controller

A shared inter-processor messaging peripheral. It holds a bank of independent mailboxes. Each one is a small first-in first-out queue of 32-bit messages. Any core on the register bus may post a message into any mailbox or take one out. No mailbox belongs to a single owner.

Each of several user cores has three registers: an event enable mask, a raw event register that is cleared by writing ones, and a masked view of the raw register. Every mailbox feeds two events to every user, "holds a message" and "has free space". Software marks a core as a receiver by enabling the first event, and as a sender by enabling the second. Each user's interrupt line is the OR of its masked events.

The bus has separate write and read channels, so a post and a fetch can happen in the same cycle. Read data appears on the cycle after the read strobe. All addresses are word indices. Mailbox `m` has its message register at `0x00+m` and its status register at `0x10+m`. User `u` has its raw events at `0x20+4u`, its masked events at `0x21+4u` and its enable mask at `0x22+4u`.

Top module: `mailbox_hub`

## Requirements
- R1: There are 12 mailboxes, each holding up to 4 messages of 32 bits. Messages are returned in the order they were written.
- R2: A write to a mailbox's message register pushes the data. A read of that register pops the oldest message, and the value appears on `rd_data` one cycle after `rd_en`.
- R3: A read of an empty mailbox returns zero and leaves its count and contents unchanged.
- R4: A write to a full mailbox is discarded and sets the sticky overflow flag at status bit 9. Writing a 1 to bit 9 of the status register clears the flag.
- R5: Mailbox status reads give the message count (0..4) in bits [7:0] and the full flag in bit 8.
- R6: A write and a read to the same mailbox in the same cycle both take effect, and the count stays the same. This also holds when the mailbox is full, in which case the write is not treated as an overflow.
- R7: Raw event register bit 2m is "mailbox m holds a message". Bit 2m+1 is "mailbox m is not full". Each bit sets on the clock after its condition is seen and stays set until it is cleared.
- R8: Writing a 1 to a raw event bit clears it. If the condition still holds, the bit sets again on the next clock.
- R9: The masked register equals raw AND enable. `irq[u]` is high exactly when user u's masked register is nonzero.
- R10: Traffic on one mailbox does not change any other mailbox.
- R11: After reset, all mailboxes are empty, all enables and raw events are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (a read pops when it targets a message register) |
| rd_addr | input | 8 | Read word address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en`, zero otherwise |
| irq | output | 4 | Per-user interrupt lines |

## Verification
The count properties assume that at most one write and one read arrive per cycle, each with a single address, and that strobes are never X after reset. The bench drives every strobe for exactly one cycle, changes inputs only on the falling edge, and uses only mapped addresses. The property for same-cycle read and write assumes the mailbox is nonempty. The bench therefore posts messages before it issues any combined access.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned MBX_N  = 12;
    localparam int unsigned USR_N  = 4;
    localparam int unsigned FIFO_D = 4;
    localparam int unsigned MSG_W  = 32;

    localparam logic [ADDR_W-1:0] MSG_BASE  = 8'h00;
    localparam logic [ADDR_W-1:0] STAT_BASE = 8'h10;
    localparam logic [ADDR_W-1:0] USR_BASE  = 8'h20;
    localparam int unsigned USR_STRIDE      = 4;

    localparam int unsigned STAT_FULL_BIT = 8;
    localparam int unsigned STAT_OVF_BIT  = 9;

    typedef enum logic [1:0] {
        UREG_RAW    = 2'd0,
        UREG_MASKED = 2'd1,
        UREG_ENABLE = 2'd2
    } ureg_e;

    // Event pair of one mailbox as seen in a user register
    typedef struct packed {
        logic has_room;
        logic has_msg;
    } mbx_evt_t;

    function automatic logic [ADDR_W-1:0] msg_addr(input int unsigned m);
        return MSG_BASE + ADDR_W'(m);
    endfunction

    function automatic logic [ADDR_W-1:0] stat_addr(input int unsigned m);
        return STAT_BASE + ADDR_W'(m);
    endfunction

    function automatic logic [ADDR_W-1:0] usr_addr(input int unsigned u, input ureg_e k);
        return USR_BASE + ADDR_W'(u * USR_STRIDE) + ADDR_W'(k);
    endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned WIDTH = 32,
    parameter int unsigned CW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full,
    output logic             ovf
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop_req && !empty;
    // a simultaneous pop frees the slot that the push needs
    assign do_push = push_req && (!full || do_pop);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push_req && !do_push) ovf <= 1'b1;
            else if (ovf_clr)         ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
    parameter int unsigned EW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [EW-1:0] evt_level,
    input  logic          clr_we,
    input  logic [EW-1:0] clr_bits,
    input  logic          en_we,
    input  logic [EW-1:0] en_bits,
    output logic [EW-1:0] raw,
    output logic [EW-1:0] masked,
    output logic [EW-1:0] en,
    output logic          irq
);
    logic [EW-1:0] clr_mask;

    assign clr_mask = clr_we ? clr_bits : '0;
    assign masked   = raw & en;
    assign irq      = |masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw <= '0;
            en  <= '0;
        end else begin
            raw <= (raw | evt_level) & ~clr_mask;
            if (en_we) en <= en_bits;
        end
    end
endmodule

// File: rtl/mailbox_hub.sv
module mailbox_hub
    import mbx_pkg::*;
#(
    parameter int unsigned N_MBX  = MBX_N,
    parameter int unsigned N_USR  = USR_N,
    parameter int unsigned DEPTH  = FIFO_D,
    parameter int unsigned DATA_W = MSG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [7:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_USR-1:0]  irq
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned EW = 2 * N_MBX;

    logic [DATA_W-1:0]            mb_head [N_MBX];
    logic [N_MBX-1:0][CW-1:0]     mb_count;
    logic [N_MBX-1:0]             mb_empty, mb_full, mb_ovf;
    mbx_evt_t [N_MBX-1:0]         evt_level;
    logic [EW-1:0]                usr_raw    [N_USR];
    logic [EW-1:0]                usr_masked [N_USR];
    logic [N_USR-1:0][EW-1:0]     usr_en;
    logic [DATA_W-1:0]            rd_mux;

    for (genvar m = 0; m < N_MBX; m++) begin : g_mbx
        mbx_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W), .CW(CW)) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .push_req (wr_en && (wr_addr == msg_addr(m))),
            .push_data(wr_data),
            .pop_req  (rd_en && (rd_addr == msg_addr(m))),
            .ovf_clr  (wr_en && (wr_addr == stat_addr(m)) && wr_data[STAT_OVF_BIT]),
            .head     (mb_head[m]),
            .count    (mb_count[m]),
            .empty    (mb_empty[m]),
            .full     (mb_full[m]),
            .ovf      (mb_ovf[m])
        );
        assign evt_level[m].has_msg  = !mb_empty[m];
        assign evt_level[m].has_room = !mb_full[m];
    end

    for (genvar u = 0; u < N_USR; u++) begin : g_usr
        mbx_user_irq #(.EW(EW)) u_irq (
            .clk      (clk),
            .rst      (rst),
            .evt_level(evt_level),
            .clr_we   (wr_en && (wr_addr == usr_addr(u, UREG_RAW))),
            .clr_bits (wr_data[EW-1:0]),
            .en_we    (wr_en && (wr_addr == usr_addr(u, UREG_ENABLE))),
            .en_bits  (wr_data[EW-1:0]),
            .raw      (usr_raw[u]),
            .masked   (usr_masked[u]),
            .en       (usr_en[u]),
            .irq      (irq[u])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int m = 0; m < N_MBX; m++) begin
            if (rd_addr == msg_addr(m))
                rd_mux = mb_empty[m] ? '0 : mb_head[m];
            if (rd_addr == stat_addr(m))
                rd_mux = DATA_W'({mb_ovf[m], mb_full[m], 8'(mb_count[m])});
        end
        for (int u = 0; u < N_USR; u++) begin
            if (rd_addr == usr_addr(u, UREG_RAW))    rd_mux = DATA_W'(usr_raw[u]);
            if (rd_addr == usr_addr(u, UREG_MASKED)) rd_mux = DATA_W'(usr_masked[u]);
            if (rd_addr == usr_addr(u, UREG_ENABLE)) rd_mux = DATA_W'(usr_en[u]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_en ? rd_mux : '0;
    end
endmodule

// File: rtl/mailbox_hub_chk.sv
module mailbox_hub_chk
    import mbx_pkg::*;
#(
    parameter int unsigned N_MBX = MBX_N,
    parameter int unsigned N_USR = USR_N,
    parameter int unsigned DEPTH = FIFO_D,
    parameter int unsigned CW    = 3,
    parameter int unsigned EW    = 24
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic [7:0]               wr_addr,
    input logic                     rd_en,
    input logic [7:0]               rd_addr,
    input logic [N_USR-1:0]         irq,
    input logic [N_MBX-1:0][CW-1:0] mb_count,
    input logic [N_MBX-1:0]         mb_ovf,
    input logic [N_USR-1:0][EW-1:0] usr_en
);
    // R11: state leaving reset
    assert_reset_quiet_R11: assert property (@(posedge clk)
        rst |=> (irq == '0 && mb_count == '0));

    for (genvar m = 0; m < N_MBX; m++) begin : g_m
        logic hw, hr;
        assign hw = wr_en && (wr_addr == msg_addr(m));
        assign hr = rd_en && (rd_addr == msg_addr(m));

        assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
            mb_count[m] <= CW'(DEPTH));

        assert_push_grows_R2: assert property (@(posedge clk) disable iff (rst)
            (hw && !hr && mb_count[m] < CW'(DEPTH)) |=> mb_count[m] == $past(mb_count[m]) + CW'(1));

        assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
            (hr && !hw && mb_count[m] == '0) |=> mb_count[m] == '0);

        assert_drop_full_R4: assert property (@(posedge clk) disable iff (rst)
            (hw && !hr && mb_count[m] == CW'(DEPTH)) |=> (mb_ovf[m] && mb_count[m] == CW'(DEPTH)));

        assert_rw_same_R6: assert property (@(posedge clk) disable iff (rst)
            (hw && hr && mb_count[m] != '0) |=> $stable(mb_count[m]));
    end

    for (genvar u = 0; u < N_USR; u++) begin : g_u
        assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
            (usr_en[u] == '0) |-> !irq[u]);
    end
endmodule

bind mailbox_hub mailbox_hub_chk #(
    .N_MBX(N_MBX), .N_USR(N_USR), .DEPTH(DEPTH), .CW(CW), .EW(EW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .irq     (irq),
    .mb_count(mb_count),
    .mb_ovf  (mb_ovf),
    .usr_en  (usr_en)
);

// File: tb/tb_mailbox_hub.sv
`timescale 1ns/1ps
module tb_mailbox_hub;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [7:0]  wr_addr, rd_addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [3:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mailbox_hub dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic do_rw(input logic [7:0] wa, input logic [31:0] wd,
                         input logic [7:0] ra, output logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = wa; wr_data = wd;
        rd_en = 1'b1; rd_addr = ra;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R11 irq after reset", {28'd0, irq}, 32'd0);
        do_rd(8'h10, v);
        chk("R11 status mb0 empty", v, 32'd0);
        do_rd(8'h22, v);
        chk("R11 enable user0 zero", v, 32'd0);
        do_rd(8'h20, v);
        chk("R7 raw user0 has only not-full bits", v, 32'h00AA_AAAA);
    endtask

    task automatic t_order;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) do_wr(8'h03, 32'hA000_0000 + i);
        do_rd(8'h13, v);
        chk("R5 full status count 4", v, 32'h0000_0104);
        for (int i = 0; i < 4; i++) begin
            do_rd(8'h03, v);
            chk("R1 R2 pop order", v, 32'hA000_0000 + i);
        end
        do_rd(8'h13, v);
        chk("R5 status empty after drain", v, 32'd0);
    endtask

    task automatic t_empty_read;
        logic [31:0] v;
        do_rd(8'h03, v);
        chk("R3 empty read returns zero", v, 32'd0);
        do_rd(8'h13, v);
        chk("R3 status unchanged", v, 32'd0);
        do_wr(8'h03, 32'h1234_5678);
        do_rd(8'h03, v);
        chk("R3 later message unaffected", v, 32'h1234_5678);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) do_wr(8'h05, 32'hB000_0000 + i);
        do_wr(8'h05, 32'hDEAD_BEEF);
        do_rd(8'h15, v);
        chk("R4 overflow flag set", v, 32'h0000_0304);
        do_rd(8'h05, v);
        chk("R4 oldest kept", v, 32'hB000_0000);
        do_wr(8'h15, 32'h0000_0200);
        do_rd(8'h15, v);
        chk("R4 overflow cleared", v, 32'h0000_0003);
        for (int i = 1; i < 4; i++) begin
            do_rd(8'h05, v);
            chk("R4 stored values", v, 32'hB000_0000 + i);
        end
        do_rd(8'h05, v);
        chk("R4 dropped word absent", v, 32'd0);
    endtask

    task automatic t_simul;
        logic [31:0] v;
        do_wr(8'h07, 32'hC000_0000);
        do_wr(8'h07, 32'hC000_0001);
        do_rw(8'h07, 32'hC000_0002, 8'h07, v);
        chk("R6 read during write", v, 32'hC000_0000);
        do_rd(8'h17, v);
        chk("R6 count unchanged", v, 32'h0000_0002);
        do_wr(8'h07, 32'hC000_0003);
        do_wr(8'h07, 32'hC000_0004);
        do_rw(8'h07, 32'hC000_0005, 8'h07, v);
        chk("R6 read during write when full", v, 32'hC000_0001);
        do_rd(8'h17, v);
        chk("R6 full, no overflow", v, 32'h0000_0104);
        for (int i = 2; i < 6; i++) begin
            do_rd(8'h07, v);
            chk("R6 drain order", v, 32'hC000_0000 + i);
        end
    endtask

    task automatic t_isolation;
        logic [31:0] v;
        do_wr(8'h00, 32'h5555_0000);
        do_rd(8'h11, v);
        chk("R10 neighbour status", v, 32'd0);
        do_rd(8'h01, v);
        chk("R10 neighbour empty", v, 32'd0);
        do_rd(8'h10, v);
        chk("R10 own count", v, 32'h0000_0001);
        do_rd(8'h00, v);
        chk("R10 own data", v, 32'h5555_0000);
    endtask

    task automatic t_new_msg_irq;
        logic [31:0] v;
        do_wr(8'h2A, 32'h0004_0000);
        chk("R9 enabled but no event", {31'd0, irq[2]}, 32'd0);
        do_wr(8'h09, 32'h0909_0909);
        @(negedge clk);
        chk("R7 irq user2 on message", {28'd0, irq}, 32'h4);
        do_rd(8'h29, v);
        chk("R9 masked status user2", v, 32'h0004_0000);
        do_wr(8'h28, 32'h0004_0000);
        chk("R8 cleared", {31'd0, irq[2]}, 32'd0);
        @(negedge clk);
        chk("R8 re-set while nonempty", {31'd0, irq[2]}, 32'd1);
        do_rd(8'h09, v);
        chk("R2 mb9 data", v, 32'h0909_0909);
        do_wr(8'h28, 32'h0004_0000);
        @(negedge clk);
        @(negedge clk);
        chk("R8 stays clear once empty", {31'd0, irq[2]}, 32'd0);
    endtask

    task automatic t_room_irq;
        logic [31:0] v;
        do_wr(8'h26, 32'h0000_0200);
        chk("R7 not-full event user1", {31'd0, irq[1]}, 32'd1);
        for (int i = 0; i < 4; i++) do_wr(8'h04, 32'hE000_0000 + i);
        do_wr(8'h24, 32'h0000_0200);
        chk("R8 cleared while full", {31'd0, irq[1]}, 32'd0);
        @(negedge clk);
        chk("R7 no re-set while full", {31'd0, irq[1]}, 32'd0);
        do_rd(8'h04, v);
        chk("R7 no event yet at pop", {31'd0, irq[1]}, 32'd0);
        @(negedge clk);
        chk("R7 not-full after pop", {31'd0, irq[1]}, 32'd1);
        for (int i = 1; i < 4; i++) begin
            do_rd(8'h04, v);
            chk("R1 mb4 data", v, 32'hE000_0000 + i);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        wr_addr = '0; rd_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_empty_read();
        t_overflow();
        t_simul();
        t_isolation();
        t_new_msg_irq();
        t_room_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule